// File: doc/BRIEF.md
# CPU Power-Mode Sequencer

This controller moves a processor among three operating modes: run, idle and sleep. It does not switch between them at once. Each move passes through a timed transition, and a tick from an external timebase paces it. In run mode the CPU clock and logic power are both on. Idle gates the CPU clock but keeps the logic powered. Sleep turns both off. Going into sleep takes three equal stages. Leaving sleep always costs the full wake latency.

The block also keeps an estimate of the energy spent. On every tick it adds a weight for the present condition to a saturating accumulator. The weights are in hundredths of a milliwatt: 40000 for run, 5000 for idle and 16 for sleep. A transition charges the weight of the more power-hungry of its two end modes, so a round trip through a low-power mode is not free. System software or a power manager raises the requests. A wake event from the interrupt logic brings the processor back.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is run (code 0), the CPU clock enable and the logic power enable are 1, busy is 0 and the energy total is 0.
- R2: Mode codes are run = 0, idle = 1 and sleep = 2.
  - The CPU clock enable is 1 only in run.
  - The logic power enable is 0 only in sleep.
  - During a transition the mode code and both enables keep the values of the mode being left.
- R3: In run, a request for idle (with no sleep request) starts a transition. Busy goes to 1 from the next clock edge, and the mode becomes idle on the edge of the 10th tick after that.
- R4: A wake event has no effect in run. In idle, a wake event starts the move to run, which completes on the 10th tick. When wake and a sleep request arrive together in idle, wake takes precedence.
- R5: A sleep request in run or in idle starts sleep entry. Entry has three stages of 30 ticks each, and the mode becomes sleep on the 90th tick. In run a sleep request takes precedence over an idle request.
- R6: Sleep is left only through a wake event. The move to run then lasts 160 ticks. Idle and sleep requests in sleep have no effect.
- R7: While a transition is in progress, busy stays 1 for the whole interval and every request and wake event is ignored.
- R8: Each tick adds a weight to the energy total. A settled mode adds its own weight: run 40000, idle 5000, sleep 16. A transition adds the larger weight of its two end modes. Without a tick the total does not change.
- R9: The energy total saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one time unit |
| req_idle | input | 1 | Request to enter idle |
| req_sleep | input | 1 | Request to enter sleep |
| wake | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| logic_pwr_en | output | 1 | Logic power enable |
| mode | output | 2 | Current settled mode code |
| busy | output | 1 | Transition in progress |
| energy | output | EW | Accumulated energy, hundredths of mW per tick |

## Verification
A wrong internal state shows up at the ports in one of three ways:

- **Timer off by one.** An off-by-one in the transition timer moves the busy fall and the mode change by one tick. The bench sees this at the tick just before and the tick just after each expected boundary.
- **Lost stage counter.** If the stage counter loses its place, sleep entry ends early or late against the 90-tick boundary.
- **Wrong source bit or weight.** A wrong source bit or weight selection does not change any mode flag. It leaves the energy total off by a known weight difference within one tick, so the exact energy value read after every scenario exposes it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_R2I,
        ST_IDLE,
        ST_I2R,
        ST_ENTER,
        ST_SLEEP,
        ST_S2R
    } pmc_state_e;

    localparam logic [1:0] MODE_RUN   = 2'd0;
    localparam logic [1:0] MODE_IDLE  = 2'd1;
    localparam logic [1:0] MODE_SLEEP = 2'd2;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int T_RI    = 10,
    parameter int T_IR    = 10,
    parameter int T_STEP  = 30,
    parameter int N_STEPS = 3,
    parameter int T_SR    = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       req_idle,
    input  logic       req_sleep,
    input  logic       wake,
    output logic [1:0] mode,
    output logic [1:0] wsel,
    output logic       busy
);
    localparam int TMAX1 = (T_RI > T_IR) ? T_RI : T_IR;
    localparam int TMAX2 = (TMAX1 > T_STEP) ? TMAX1 : T_STEP;
    localparam int TMAX  = (TMAX2 > T_SR) ? TMAX2 : T_SR;
    localparam int CW    = $clog2(TMAX + 1);
    localparam int SW    = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

    typedef struct packed {
        pmc_state_e    st;
        logic [CW-1:0] cnt;
        logic [SW-1:0] step;
        logic          from_run;
    } seq_t;

    seq_t s_d, s_q;
    logic expire;

    assign expire = tick && (s_q.cnt == CW'(1));

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_RUN: begin
                if (req_sleep) begin
                    s_d.st       = ST_ENTER;
                    s_d.cnt      = CW'(T_STEP);
                    s_d.step     = '0;
                    s_d.from_run = 1'b1;
                end else if (req_idle) begin
                    s_d.st  = ST_R2I;
                    s_d.cnt = CW'(T_RI);
                end
            end
            ST_IDLE: begin
                if (wake) begin
                    s_d.st  = ST_I2R;
                    s_d.cnt = CW'(T_IR);
                end else if (req_sleep) begin
                    s_d.st       = ST_ENTER;
                    s_d.cnt      = CW'(T_STEP);
                    s_d.step     = '0;
                    s_d.from_run = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    s_d.st  = ST_S2R;
                    s_d.cnt = CW'(T_SR);
                end
            end
            ST_R2I, ST_I2R, ST_S2R: begin
                if (expire) begin
                    s_d.st  = (s_q.st == ST_R2I) ? ST_IDLE : ST_RUN;
                    s_d.cnt = '0;
                end else if (tick) begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            ST_ENTER: begin
                if (expire) begin
                    if (s_q.step == SW'(N_STEPS - 1)) begin
                        s_d.st   = ST_SLEEP;
                        s_d.cnt  = '0;
                        s_d.step = '0;
                    end else begin
                        s_d.step = s_q.step + SW'(1);
                        s_d.cnt  = CW'(T_STEP);
                    end
                end else if (tick) begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_RUN, cnt: '0, step: '0, from_run: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy = 1'b1;
        mode = MODE_RUN;
        wsel = MODE_RUN;
        case (s_q.st)
            ST_RUN:   busy = 1'b0;
            ST_R2I:   mode = MODE_RUN;
            ST_IDLE: begin
                busy = 1'b0;
                mode = MODE_IDLE;
                wsel = MODE_IDLE;
            end
            ST_I2R:   mode = MODE_IDLE;
            ST_ENTER: begin
                mode = s_q.from_run ? MODE_RUN : MODE_IDLE;
                wsel = s_q.from_run ? MODE_RUN : MODE_IDLE;
            end
            ST_SLEEP: begin
                busy = 1'b0;
                mode = MODE_SLEEP;
                wsel = MODE_SLEEP;
            end
            ST_S2R:   mode = MODE_SLEEP;
            default:  busy = 1'b0;
        endcase
    end

    AST_HOLD_IN_TRANSIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(mode))); // R7

    AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && $past(mode) != MODE_SLEEP) |-> $past(busy)); // R5

    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_SLEEP && mode != MODE_SLEEP) |-> (mode == MODE_RUN)); // R6
endmodule

// File: rtl/pmc_energy.sv
module pmc_energy
    import pmc_pkg::*;
#(
    parameter int EW      = 32,
    parameter int W_RUN   = 40000,
    parameter int W_IDLE  = 5000,
    parameter int W_SLEEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    wsel,
    output logic [EW-1:0] energy
);
    typedef struct packed {
        logic [EW-1:0] acc;
    } en_t;

    en_t e_d, e_q;
    logic [EW-1:0] weight;
    logic [EW:0]   sum;

    always_comb begin
        case (wsel)
            MODE_IDLE:  weight = EW'(W_IDLE);
            MODE_SLEEP: weight = EW'(W_SLEEP);
            default:    weight = EW'(W_RUN);
        endcase
        sum = {1'b0, e_q.acc} + {1'b0, weight};
        e_d = e_q;
        if (tick) begin
            e_d.acc = sum[EW] ? {EW{1'b1}} : sum[EW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{acc: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign energy = e_q.acc;

    AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(energy)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (energy >= $past(energy))); // R9
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int EW      = 32,
    parameter int T_RI    = 10,
    parameter int T_IR    = 10,
    parameter int T_STEP  = 30,
    parameter int N_STEPS = 3,
    parameter int T_SR    = 160,
    parameter int W_RUN   = 40000,
    parameter int W_IDLE  = 5000,
    parameter int W_SLEEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          req_idle,
    input  logic          req_sleep,
    input  logic          wake,
    output logic          cpu_clk_en,
    output logic          logic_pwr_en,
    output logic [1:0]    mode,
    output logic          busy,
    output logic [EW-1:0] energy
);
    logic [1:0] wsel;

    pmc_seq #(
        .T_RI(T_RI), .T_IR(T_IR), .T_STEP(T_STEP),
        .N_STEPS(N_STEPS), .T_SR(T_SR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_idle(req_idle), .req_sleep(req_sleep), .wake(wake),
        .mode(mode), .wsel(wsel), .busy(busy)
    );

    pmc_energy #(
        .EW(EW), .W_RUN(W_RUN), .W_IDLE(W_IDLE), .W_SLEEP(W_SLEEP)
    ) u_energy (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wsel(wsel), .energy(energy)
    );

    assign cpu_clk_en   = (mode == MODE_RUN);
    assign logic_pwr_en = (mode != MODE_SLEEP);

    AST_SLEEP_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP) |-> (!cpu_clk_en && !logic_pwr_en)); // R2
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int EW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic req_idle = 1'b0;
    logic req_sleep = 1'b0;
    logic wake = 1'b0;
    logic cpu_clk_en, logic_pwr_en, busy;
    logic [1:0] mode;
    logic [EW-1:0] energy;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.EW(EW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_idle(req_idle), .req_sleep(req_sleep), .wake(wake),
        .cpu_clk_en(cpu_clk_en), .logic_pwr_en(logic_pwr_en),
        .mode(mode), .busy(busy), .energy(energy)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 0; req_idle = 0; req_sleep = 0; wake = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse(input logic i, input logic s, input logic w);
        @(negedge clk);
        req_idle = i; req_sleep = s; wake = w;
        @(negedge clk);
        req_idle = 0; req_sleep = 0; wake = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", 32'(mode), 0);
        chk("R1 clk_en", 32'(cpu_clk_en), 1);
        chk("R1 pwr_en", 32'(logic_pwr_en), 1);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 energy", 32'(energy), 0);
        ticks(3);
        chk("R8 run energy", 32'(energy), 120000);
        pulse(0, 0, 1);
        chk("R4 wake in run busy", 32'(busy), 0);
        chk("R4 wake in run mode", 32'(mode), 0);
        repeat (4) @(negedge clk);
        chk("R8 no tick stable", 32'(energy), 120000);
    endtask

    task automatic t_run_idle();
        do_reset();
        pulse(1, 0, 0);
        chk("R3 busy start", 32'(busy), 1);
        chk("R2 mode held", 32'(mode), 0);
        chk("R2 clk held", 32'(cpu_clk_en), 1);
        ticks(9);
        chk("R3 busy at 9", 32'(busy), 1);
        ticks(1);
        chk("R3 busy at 10", 32'(busy), 0);
        chk("R3 mode idle", 32'(mode), 1);
        chk("R2 idle clk", 32'(cpu_clk_en), 0);
        chk("R2 idle pwr", 32'(logic_pwr_en), 1);
        chk("R8 r2i energy", 32'(energy), 400000);
        ticks(4);
        chk("R8 idle energy", 32'(energy), 420000);
        pulse(1, 0, 0);
        chk("R3 idle req in idle", 32'(busy), 0);
        pulse(0, 1, 1);
        chk("R4 wake busy", 32'(busy), 1);
        ticks(9);
        chk("R4 busy at 9", 32'(busy), 1);
        chk("R4 mode held", 32'(mode), 1);
        ticks(1);
        chk("R4 mode run", 32'(mode), 0);
        chk("R4 busy done", 32'(busy), 0);
        chk("R8 i2r energy", 32'(energy), 820000);
    endtask

    task automatic t_sleep_run();
        do_reset();
        pulse(1, 1, 0);
        chk("R5 busy", 32'(busy), 1);
        ticks(30);
        chk("R5 busy at 30", 32'(busy), 1);
        chk("R5 mode at 30", 32'(mode), 0);
        chk("R5 clk at 30", 32'(cpu_clk_en), 1);
        pulse(0, 0, 1);
        ticks(59);
        chk("R7 busy at 89", 32'(busy), 1);
        ticks(1);
        chk("R5 busy at 90", 32'(busy), 0);
        chk("R5 mode sleep", 32'(mode), 2);
        chk("R2 sleep clk", 32'(cpu_clk_en), 0);
        chk("R2 sleep pwr", 32'(logic_pwr_en), 0);
        chk("R8 entry energy", 32'(energy), 3600000);
        ticks(10);
        chk("R8 sleep energy", 32'(energy), 3600160);
        pulse(1, 1, 0);
        chk("R6 reqs in sleep busy", 32'(busy), 0);
        chk("R6 reqs in sleep mode", 32'(mode), 2);
        pulse(0, 0, 1);
        chk("R6 wake busy", 32'(busy), 1);
        ticks(159);
        chk("R6 busy at 159", 32'(busy), 1);
        chk("R6 mode at 159", 32'(mode), 2);
        ticks(1);
        chk("R6 mode run", 32'(mode), 0);
        chk("R6 busy done", 32'(busy), 0);
        chk("R8 s2r energy", 32'(energy), 10000160);
    endtask

    task automatic t_sleep_idle();
        do_reset();
        pulse(1, 0, 0);
        ticks(10);
        pulse(0, 1, 0);
        chk("R5 from idle busy", 32'(busy), 1);
        chk("R5 from idle mode", 32'(mode), 1);
        ticks(89);
        chk("R5 from idle at 89", 32'(busy), 1);
        ticks(1);
        chk("R5 from idle sleep", 32'(mode), 2);
        chk("R8 idle entry energy", 32'(energy), 850000);
    endtask

    task automatic t_transit_ignore();
        do_reset();
        pulse(1, 0, 0);
        ticks(3);
        pulse(0, 0, 1);
        pulse(0, 1, 0);
        ticks(7);
        chk("R7 settled idle", 32'(mode), 1);
        chk("R7 not busy", 32'(busy), 0);
    endtask

    task automatic t_saturate();
        do_reset();
        ticks(420);
        chk("R9 saturated", 32'(energy), 32'h00FF_FFFF);
        ticks(5);
        chk("R9 held", 32'(energy), 32'h00FF_FFFF);
    endtask

    initial begin
        t_reset();
        t_run_idle();
        t_sleep_run();
        t_sleep_idle();
        t_transit_ignore();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule